// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in. It returns a 16-bit sum and a carry-out. The logic is purely combinational. The operand width is split into four 4-bit slices. Inside each slice, every bit carry is formed in parallel as a flat sum of products. The products use the bit generate (a AND b), the bit propagate (a XOR b) and the slice's incoming carry.

Each slice also reports a group propagate and a group generate. A second-level lookahead unit combines these group pairs with the block carry-in, using the same equations as the bit level. It forms the carries into the upper slices and the final carry-out at the same time, so no carry ripples from one slice to the next.

The block has no clock and no handshake. Operands are applied to the inputs, and the results are valid once the logic settles.

Top module: `lookahead_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `a + b + cin`, taken as unsigned numbers.
- R2: `cout` equals bit 16 of `a + b + cin`.
- R3: The group propagate of a slice is the AND of `a[i] ^ b[i]` over its four bits. A slice whose bits all propagate passes its incoming carry straight through to the next slice.
- R4: The group generate of a slice is the carry that the slice produces with a zero carry-in. A slice that generates a carry sets the next slice's carry-in whatever the carry below it.
- R5: The carry into slice k+1 is `gg[k] | gp[k] & c[k]`, where slice 0 covers bits [3:0] and takes `cin`. Slices 1, 2 and 3 cover bits [7:4], [11:8] and [15:12].
- R6: `a = 16'hFFFF`, `b = 16'h0001`, `cin = 0` gives `sum = 16'h0000` and `cout = 1`. So does `a = 16'hFFFF`, `b = 0`, `cin = 1`.
- R7: `a = b = 16'hFFFF` with `cin = 1` gives `sum = 16'hFFFF` and `cout = 1`.
- R8: When `a ^ b` is all ones, `cout` equals `cin`, and every bit of `sum` equals `~cin`.
- R9: The outputs are a function of the present inputs only. Applying the same inputs again gives the same result whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the result |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The bench drives carries that must cross slice boundaries: an increment that ripples through a full slice, through two slices and through all four. A second-level unit with a missing product term, or with the wrong slice indices, drops the upper sum bits in these cases. The full-propagate case (`a ^ b` all ones) with both carry-in values checks that `cin` reaches `cout` through every group propagate. A design that ANDed the wrong propagates would leave `cout` stuck. The all-ones cases with carry-in set catch a group generate that omits a term, because the sum would then lose its top bits. A set of pseudo-random vectors compared against plain addition covers mixed generate and propagate patterns.

// File: rtl/cla_pkg.sv
`timescale 1ns/1ps
package cla_pkg;
  parameter int unsigned CLA_WIDTH = 16;
  parameter int unsigned CLA_SLICE = 4;

  typedef struct packed {
    logic prop;
    logic gen;
  } grp_sig_t;
endpackage

// File: rtl/cla_lookahead.sv
`timescale 1ns/1ps
// Generic lookahead unit: every carry is a flat sum of products.
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  input  logic         cin,
  output logic [N-1:0] carry,
  output logic         grp_p,
  output logic         grp_g
);
  always_comb begin
    logic acc;
    logic run;
    for (int k = 0; k < N; k++) begin
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        run = g[j];
        for (int m = j + 1; m < k; m++) run = run & p[m];
        acc = acc | run;
      end
      run = cin;
      for (int m = 0; m < k; m++) run = run & p[m];
      carry[k] = acc | run;
    end
  end

  // Group generate: carry out of the top position assuming zero carry-in.
  always_comb begin
    logic acc;
    logic run;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      run = g[j];
      for (int m = j + 1; m < N; m++) run = run & p[m];
      acc = acc | run;
    end
    grp_g = acc;
  end

  assign grp_p = &p;
endmodule

// File: rtl/cla_slice.sv
`timescale 1ns/1ps
module cla_slice #(
  parameter int unsigned SLICE = 4
) (
  input  logic [SLICE-1:0] a,
  input  logic [SLICE-1:0] b,
  input  logic             cin,
  output logic [SLICE-1:0] sum,
  output cla_pkg::grp_sig_t grp
);
  logic [SLICE-1:0] bit_p;
  logic [SLICE-1:0] bit_g;
  logic [SLICE-1:0] bit_c;
  logic             gp;
  logic             gg;

  assign bit_p = a ^ b;
  assign bit_g = a & b;

  cla_lookahead #(.N(SLICE)) u_bits (
    .p     (bit_p),
    .g     (bit_g),
    .cin   (cin),
    .carry (bit_c),
    .grp_p (gp),
    .grp_g (gg)
  );

  assign sum      = bit_p ^ bit_c;
  assign grp.prop = gp;
  assign grp.gen  = gg;
endmodule

// File: rtl/lookahead_adder.sv
`timescale 1ns/1ps
module lookahead_adder #(
  parameter int unsigned WIDTH = cla_pkg::CLA_WIDTH,
  parameter int unsigned SLICE = cla_pkg::CLA_SLICE
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int unsigned NSLICE = WIDTH / SLICE;

  cla_pkg::grp_sig_t [NSLICE-1:0] slice_grp;
  logic [NSLICE-1:0] slice_gp;
  logic [NSLICE-1:0] slice_gg;
  logic [NSLICE-1:0] slice_c;
  logic              top_gp;
  logic              top_gg;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    cla_slice #(.SLICE(SLICE)) u_slice (
      .a   (a[s*SLICE +: SLICE]),
      .b   (b[s*SLICE +: SLICE]),
      .cin (slice_c[s]),
      .sum (sum[s*SLICE +: SLICE]),
      .grp (slice_grp[s])
    );
    assign slice_gp[s] = slice_grp[s].prop;
    assign slice_gg[s] = slice_grp[s].gen;
  end

  // Second level: carries into every slice at once from group pairs.
  cla_lookahead #(.N(NSLICE)) u_groups (
    .p     (slice_gp),
    .g     (slice_gg),
    .cin   (cin),
    .carry (slice_c),
    .grp_p (top_gp),
    .grp_g (top_gg)
  );

  assign cout = top_gg | (top_gp & cin);
endmodule

// File: rtl/lookahead_adder_chk.sv
`timescale 1ns/1ps
module lookahead_adder_chk #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned SLICE  = 4,
  parameter int unsigned NSLICE = WIDTH / SLICE
) (
  input logic [WIDTH-1:0]  a,
  input logic [WIDTH-1:0]  b,
  input logic              cin,
  input logic [WIDTH-1:0]  sum,
  input logic              cout,
  input logic [NSLICE-1:0] slice_gp,
  input logic [NSLICE-1:0] slice_gg,
  input logic [NSLICE-1:0] slice_c
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    // R1, R2
    a_r1_sum_value: assert (sum == ref_total[WIDTH-1:0])
      else $error("sum disagrees with a+b+cin");
    a_r2_carry_out: assert (cout == ref_total[WIDTH])
      else $error("cout disagrees with a+b+cin");
    // R8
    if (&(a ^ b)) begin
      a_r8_full_propagate: assert (cout == cin)
        else $error("full propagate did not pass cin to cout");
    end
    for (int s = 0; s < NSLICE; s++) begin
      // R3
      a_r3_group_prop: assert (slice_gp[s] == &(a[s*SLICE +: SLICE] ^ b[s*SLICE +: SLICE]))
        else $error("group propagate wrong in slice %0d", s);
      // R4
      a_r4_group_gen: assert (slice_gg[s] ==
          ((({1'b0, a[s*SLICE +: SLICE]} + {1'b0, b[s*SLICE +: SLICE]}) >> SLICE) != 0))
        else $error("group generate wrong in slice %0d", s);
    end
    // R5
    a_r5_slice0_cin: assert (slice_c[0] == cin)
      else $error("slice 0 carry-in is not cin");
    for (int s = 1; s < NSLICE; s++) begin
      a_r5_slice_carry: assert (slice_c[s] == (slice_gg[s-1] | (slice_gp[s-1] & slice_c[s-1])))
        else $error("carry into slice %0d wrong", s);
    end
  end
endmodule

bind lookahead_adder lookahead_adder_chk #(.WIDTH(WIDTH), .SLICE(SLICE)) u_chk (
  .a        (a),
  .b        (b),
  .cin      (cin),
  .sum      (sum),
  .cout     (cout),
  .slice_gp (slice_gp),
  .slice_gg (slice_gg),
  .slice_c  (slice_c)
);

// File: tb/test_lookahead_adder.sv
`timescale 1ns/1ps
module test_lookahead_adder;
  logic        clk = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;
  int          n_checks = 0;
  int          n_fail = 0;
  int          cycles = 0;
  bit          finished = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  lookahead_adder i_lookahead_adder (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  task automatic apply(input logic [15:0] av, input logic [15:0] bv, input logic ci);
    @(negedge clk);
    a = av; b = bv; cin = ci;
    #1;
  endtask

  task automatic expect_out(input logic [15:0] es, input logic ec, input string req);
    n_checks++;
    if (sum !== es || cout !== ec) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%b got sum=%h cout=%b expected sum=%h cout=%b",
               req, a, b, cin, sum, cout, es, ec);
    end
  endtask

  task automatic check_ref(input logic [15:0] av, input logic [15:0] bv, input logic ci,
                           input string req);
    logic [16:0] t;
    apply(av, bv, ci);
    t = {1'b0, av} + {1'b0, bv} + {16'd0, ci};
    expect_out(t[15:0], t[16], req);
  endtask

  task automatic t_idle;
    apply(16'h0000, 16'h0000, 1'b0);
    expect_out(16'h0000, 1'b0, "R1 zero inputs");
  endtask

  task automatic t_carry_in;
    check_ref(16'h0000, 16'h0000, 1'b1, "R2 cin only");
    check_ref(16'h8000, 16'h8000, 1'b0, "R2 top bit carry");
    check_ref(16'h1234, 16'h4321, 1'b1, "R1 no carries");
  endtask

  task automatic t_slice_boundaries;
    apply(16'h000F, 16'h0001, 1'b0); expect_out(16'h0010, 1'b0, "R5 into slice 1");
    apply(16'h00FF, 16'h0000, 1'b1); expect_out(16'h0100, 1'b0, "R5 into slice 2");
    apply(16'h0FFF, 16'h0001, 1'b0); expect_out(16'h1000, 1'b0, "R5 into slice 3");
  endtask

  task automatic t_group_prop;
    apply(16'h0F0F, 16'h00F0, 1'b1); expect_out(16'h1000, 1'b0, "R3 propagate chain");
    apply(16'h0A5A, 16'h05A5, 1'b0); expect_out(16'h0FFF, 1'b0, "R3 propagate no cin");
  endtask

  task automatic t_group_gen;
    apply(16'h0008, 16'h0008, 1'b0); expect_out(16'h0010, 1'b0, "R4 slice 0 generates");
    apply(16'h0880, 16'h0780, 1'b0); expect_out(16'h1000, 1'b0, "R4 generate through propagate");
  endtask

  task automatic t_all_ones_plus_one;
    apply(16'hFFFF, 16'h0001, 1'b0); expect_out(16'h0000, 1'b1, "R6 ffff+1");
    apply(16'hFFFF, 16'h0000, 1'b1); expect_out(16'h0000, 1'b1, "R6 ffff+cin");
  endtask

  task automatic t_all_ones_both;
    apply(16'hFFFF, 16'hFFFF, 1'b1); expect_out(16'hFFFF, 1'b1, "R7 ffff+ffff+1");
    apply(16'hFFFF, 16'hFFFF, 1'b0); expect_out(16'hFFFE, 1'b1, "R7 ffff+ffff");
  endtask

  task automatic t_full_propagate;
    apply(16'hA5C3, 16'h5A3C, 1'b0); expect_out(16'hFFFF, 1'b0, "R8 cin=0");
    apply(16'hA5C3, 16'h5A3C, 1'b1); expect_out(16'h0000, 1'b1, "R8 cin=1");
  endtask

  task automatic t_history;
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'h0003, 16'h0004, 1'b0); expect_out(16'h0007, 1'b0, "R9 after all ones");
    apply(16'h0000, 16'h0000, 1'b0);
    apply(16'h0003, 16'h0004, 1'b0); expect_out(16'h0007, 1'b0, "R9 after zeros");
  endtask

  task automatic t_random;
    for (int i = 0; i < 2000; i++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      check_ref(rng[15:0], rng[31:16], rng[7] ^ rng[20], "R1 R2 random");
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got cycles=%0d expected below 100000", cycles);
      finish_run();
    end
  end

  initial begin
    t_idle();
    t_carry_in();
    t_slice_boundaries();
    t_group_prop();
    t_group_gen();
    t_all_ones_plus_one();
    t_all_ones_both();
    t_full_propagate();
    t_history();
    t_random();
    finish_run();
  end
endmodule